// File: doc/BRIEF.md
# Coin-Operated Drink Vending Controller

This block is a small synchronous controller for a single-product drink machine priced at 150p. Two coin-pulse inputs report a 50p coin or a 100p coin. The controller keeps a running credit, which is always 0p, 50p or 100p. When a coin lifts the credit to 150p or more, the controller releases one drink. If the last coin overshoots the price by 50p, it also returns a single 50p coin.

Each credit level has exactly one state; equivalent states are merged. The two outputs are decoded from the state register alone, so they change only at a clock edge and stay flat for a whole cycle. A dispense state lasts one cycle and always falls back to zero credit. A synchronous reset puts the machine in the zero-credit state.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine at zero credit. In the following cycle both `vend` and `change` are low.
- R2: A 50p pulse (`coin_half`=1, `coin_full`=0) arriving when the credit is 0p or 50p raises the credit by 50p. From 100p it raises the credit to 150p.
- R3: A 100p pulse (`coin_full`=1, `coin_half`=0) raises the credit by 100p.
- R4: When the credit reaches exactly 150p, `vend` is high and `change` is low for exactly one cycle.
- R5: When the credit reaches 200p (a 100p coin on top of 100p credit), `vend` and `change` are both high for one cycle. `change` is never high without `vend`.
- R6: In a cycle with no coin pulse, the credit is held.
- R7: A coin pulse seen during a dispense cycle is ignored. The next state is zero credit.
- R8: When both coin inputs are high in the same cycle, the credit is held and neither coin is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_half | input | 1 | One-cycle pulse: a 50p coin was inserted |
| coin_full | input | 1 | One-cycle pulse: a 100p coin was inserted |
| vend | output | 1 | Release one drink (high for one cycle) |
| change | output | 1 | Return one 50p coin (high for one cycle) |

## Verification
Every result is due exactly one rising edge after the coin pulse that causes it. The state register is the only register between the inputs and the outputs.

The bench drives the inputs on the falling edge and samples the outputs shortly after the next rising edge. It compares them with a credit model updated for that same edge.

Every four-step sequence drawn from {none, 50p, 100p, both} is applied after a reset. Each sequence is followed by a 100p coin and a 50p coin, so that any wrongly held or wrongly cleared credit shows up on `vend` and `change`.

// File: rtl/vend_ctrl.sv
module vend_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic coin_half,
  input  logic coin_full,
  output logic vend,
  output logic change
);

  typedef enum logic [2:0] {
    CR_0    = 3'd0,
    CR_50   = 3'd1,
    CR_100  = 3'd2,
    PAY     = 3'd3,
    PAY_CHG = 3'd4
  } st_t;

  st_t st, st_nx;

  logic only_half, only_full;
  assign only_half = coin_half & ~coin_full;
  assign only_full = coin_full & ~coin_half;

  always_comb begin
    st_nx = st;
    case (st)
      CR_0: begin
        if (only_half) st_nx = CR_50;
        else if (only_full) st_nx = CR_100;
      end
      CR_50: begin
        if (only_half) st_nx = CR_100;
        else if (only_full) st_nx = PAY;
      end
      CR_100: begin
        if (only_half) st_nx = PAY;
        else if (only_full) st_nx = PAY_CHG;
      end
      default: st_nx = CR_0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= CR_0;
    else     st <= st_nx;
  end

  assign vend   = (st == PAY) || (st == PAY_CHG);
  assign change = (st == PAY_CHG);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (st == CR_0 && !vend && !change));

  a_r2_half_from_zero: assert property (@(posedge clk) disable iff (rst)
    (st == CR_0 && coin_half && !coin_full) |=> (st == CR_50));

  a_r3_full_from_fifty: assert property (@(posedge clk) disable iff (rst)
    (st == CR_50 && coin_full && !coin_half) |=> (vend && !change));

  a_r4_vend_single: assert property (@(posedge clk) disable iff (rst)
    vend |=> !vend);

  a_r5_change_needs_vend: assert property (@(posedge clk) disable iff (rst)
    change |-> vend);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!vend && !coin_half && !coin_full) |=> (st == $past(st)));

  a_r7_pay_to_zero: assert property (@(posedge clk) disable iff (rst)
    vend |=> (st == CR_0));

  a_r8_both_hold: assert property (@(posedge clk) disable iff (rst)
    (!vend && coin_half && coin_full) |=> (st == $past(st)));

endmodule

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_half = 1'b0;
  logic coin_full = 1'b0;
  logic vend, change;

  int checks = 0;
  int errors = 0;
  int credit = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vend_ctrl u0 (
    .clk(clk), .rst(rst), .coin_half(coin_half), .coin_full(coin_full),
    .vend(vend), .change(change)
  );

  task automatic check(input string req, input logic exp_v, input logic exp_c);
    checks++;
    if (vend !== exp_v || change !== exp_c) begin
      errors++;
      $display("FAIL %s credit=%0d vend/change actual=%b%b expected=%b%b",
               req, credit, vend, change, exp_v, exp_c);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; coin_half = 1'b0; coin_full = 1'b0;
    @(posedge clk); #1;
    credit = 0;
    check("R1", 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic h, input logic f);
    string req;
    @(negedge clk);
    coin_half = h; coin_full = f;
    if (credit >= 150) begin
      credit = 0; req = "R7";
    end else if (h && f) begin
      req = "R8";
    end else if (!h && !f) begin
      req = "R6";
    end else begin
      credit = credit + (h ? 50 : 100);
      req = (credit == 200) ? "R5" : (credit == 150) ? "R4" : h ? "R2" : "R3";
    end
    @(posedge clk); #1;
    check(req, credit >= 150, credit == 200);
  endtask

  initial begin
    do_reset();
    for (int s = 0; s < 256; s++) begin
      do_reset();
      for (int k = 0; k < 4; k++) begin
        int p;
        p = (s >> (2 * k)) & 3;
        step(p[0], p[1]);
      end
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    do_reset();
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule